// File: doc/BRIEF.md
# 8-bit host bus controller

The controller is a master for an external 8-bit parallel bus. An internal requester gives it a single-byte read or write as an address, write data and a direction bit. The controller turns this into a strobed transaction on the external pins: an active-low chip select, active-low read and write strobes, an address latch enable and an 8-bit data path. The data path is split into output data, an output enable and input data. The requester sees a ready signal while the controller is idle. When the transfer finishes it gets a one-cycle done pulse, with the read byte for reads.

Four wiring styles share one sequencing engine. A configuration input selects the style and sets separate wait-state counts for the read and write strobes. The styles are:
- multiplexed address/data on the same eight lines;
- separate address lines;
- continuous reads, where the read strobe is held open and only the address moves;
- an address-less FIFO style that waits for the external full or empty flag before it strobes.

The configuration is sampled when a request is accepted.

Top module: `hb8_ctrl`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, the address latch enable is low, ready is high and done is low.
- R2: A write holds the write strobe low for 2*(W+1) consecutive clocks, where W is the 2-bit write wait-state input (0..3 gives 2, 4, 6 or 8).
- R3: A read holds the read strobe low for 2*(R+1) consecutive clocks, where R is the 2-bit read wait-state input.
- R4: The address phase is always exactly one clock, whatever the wait-state inputs. The strobe follows it directly, and done is high in the clock after the strobe ends. Counting the clock after acceptance as 1, done appears at clock N+2, where N is the strobe length.
- R5: Mode 2'b00 (multiplexed) behaves as follows in its address clock: latch enable is high, the data output carries the low byte of the address, and output enable is high. During a write strobe the data output carries the write byte with output enable high. During a read strobe output enable is low.
- R6: In modes 2'b01 (separate) and 2'b10 (continuous), latch enable never rises and the address output carries the full request address throughout the strobe. In modes 2'b00 and 2'b11 the address output is zero. In modes 2'b00, 2'b01 and 2'b10, the FIFO flags have no effect.
- R7: In mode 2'b10, after a read, chip select and the read strobe stay low through done and idle. A following mode 2'b10 read then skips the address phase: its strobe starts in clock 1 and done appears at clock N+1. Any other request, or an idle clock with the mode input set to something else, releases both signals.
- R8: In mode 2'b11 (FIFO) there is no address phase and no latch enable. Instead a qualification phase of at least one clock holds a write while the FIFO-full input is high and holds a read while the FIFO-empty input is high. The strobe starts in the clock after the flag is seen low.
- R9: Read data is captured from the input data bus on the edge that ends the read strobe. It is presented together with a done pulse exactly one clock long.
- R10: Chip select is low from the first clock after acceptance to the end of the strobe. Ready is high only when idle. The read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Wiring style: 00 multiplexed, 01 separate, 10 continuous read, 11 FIFO |
| cfg_rd_ws_i | input | 2 | Read wait states |
| cfg_wr_ws_i | input | 2 | Write wait states |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken this edge if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | 8 | Write byte |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Captured read byte |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read / output-enable strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_ale_o | output | 1 | Address latch enable |
| bus_addr_o | output | AW | Separate address lines |
| bus_ad_o | output | 8 | Data (and multiplexed address) out |
| bus_ad_oe_o | output | 1 | Output enable for bus_ad_o |
| bus_ad_i | input | 8 | Data in |
| fifo_full_i | input | 1 | External FIFO full |
| fifo_empty_i | input | 1 | External FIFO empty |

## Verification
The hardest state to reach is the held-open continuous read. It exists only when one continuous-mode read has just finished and nothing has disturbed the idle cycles since then. The bench reaches it with back-to-back mode 2'b10 reads inside the wait-state sweep. It then leaves it by changing the mode during an idle clock, and separately by issuing a write in the same mode. For the FIFO style, the bench holds the relevant flag high and drops it at a known clock, so it can predict exactly when the strobe and done appear.

// File: rtl/hb8_pkg.sv
package hb8_pkg;
  typedef enum logic [1:0] {
    MODE_MUX  = 2'd0,
    MODE_SEP  = 2'd1,
    MODE_CONT = 2'd2,
    MODE_FIFO = 2'd3
  } hb_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_QUAL,
    ST_DATA,
    ST_DONE
  } hb_state_e;
endpackage

// File: rtl/hb8_strobe_timer.sv
module hb8_strobe_timer #(
  parameter int WSW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [WSW-1:0] ws_i,
  output logic           active_o,
  output logic           last_o
);
  localparam int CW = WSW + 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  // load 2*ws+1, count to zero: strobe lasts 2*(ws+1) clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= {ws_i, 1'b1};
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = run_q;
  assign last_o   = run_q && (cnt_q == '0);

  p_start_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);
  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_o);
endmodule

// File: rtl/hb8_pad_mux.sv
module hb8_pad_mux
  import hb8_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  hb_mode_e        mode_i,
  input  logic            addr_ph_i,
  input  logic            data_ph_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            ale_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic [AW-1:0]   addr_o
);
  logic mux_addr;
  assign mux_addr = addr_ph_i && (mode_i == MODE_MUX);

  assign ale_o   = mux_addr;
  assign ad_o    = mux_addr ? addr_i[DW-1:0] : wdata_i;
  assign ad_oe_o = mux_addr || (data_ph_i && wr_i);
  assign addr_o  = (mode_i == MODE_SEP || mode_i == MODE_CONT) ? addr_i : '0;

  always_comb begin
    if (ale_o) assert (mode_i == MODE_MUX) else $error("p_ale_mux_only_r6");
  end
endmodule

// File: rtl/hb8_ctrl.sv
module hb8_ctrl
  import hb8_pkg::*;
#(
  parameter int AW  = 16,
  parameter int WSW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_mode_i,
  input  logic [WSW-1:0] cfg_rd_ws_i,
  input  logic [WSW-1:0] cfg_wr_ws_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_wdata_i,
  output logic          rsp_done_o,
  output logic [7:0]    rsp_rdata_o,
  output logic          bus_cs_no,
  output logic          bus_rd_no,
  output logic          bus_wr_no,
  output logic          bus_ale_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_ad_o,
  output logic          bus_ad_oe_o,
  input  logic [7:0]    bus_ad_i,
  input  logic          fifo_full_i,
  input  logic          fifo_empty_i
);
  localparam int DW = 8;

  hb_state_e      state_q, state_d;
  hb_mode_e       mode_q, cfg_mode;
  logic           wr_q, open_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [WSW-1:0] ws_q, ws_sel, tmr_ws;
  logic           accept, cont_go, tmr_start, tmr_active, tmr_last, qual_ok;

  assign cfg_mode = hb_mode_e'(cfg_mode_i);
  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign cont_go  = open_q && (cfg_mode == MODE_CONT) && !req_write_i;
  assign ws_sel   = req_write_i ? cfg_wr_ws_i : cfg_rd_ws_i;
  assign qual_ok  = wr_q ? !fifo_full_i : !fifo_empty_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (cont_go)                     state_d = ST_DATA;
        else if (cfg_mode == MODE_FIFO)  state_d = ST_QUAL;
        else                             state_d = ST_ADDR;
      end
      ST_ADDR: state_d = ST_DATA;
      ST_QUAL: if (qual_ok) state_d = ST_DATA;
      ST_DATA: if (tmr_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_start = (state_d == ST_DATA) && (state_q != ST_DATA);
  // continuous reads start straight from idle, before ws_q is loaded
  assign tmr_ws    = (state_q == ST_IDLE) ? ws_sel : ws_q;

  hb8_strobe_timer #(.WSW(WSW)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .ws_i     (tmr_ws),
    .active_o (tmr_active),
    .last_o   (tmr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_MUX;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ws_q    <= '0;
      open_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q  <= cfg_mode;
        wr_q    <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        ws_q    <= ws_sel;
      end
      if (state_q == ST_DATA && tmr_last && !wr_q) rdata_q <= bus_ad_i;
      if (state_q == ST_DATA && tmr_last && !wr_q && mode_q == MODE_CONT)
        open_q <= 1'b1;
      else if (state_q == ST_IDLE &&
               ((accept && !cont_go) || (!req_valid_i && cfg_mode != MODE_CONT)))
        open_q <= 1'b0;
    end
  end

  hb8_pad_mux #(.AW(AW), .DW(DW)) i_pads (
    .mode_i    (mode_q),
    .addr_ph_i (state_q == ST_ADDR),
    .data_ph_i (state_q == ST_DATA),
    .wr_i      (wr_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .ale_o     (bus_ale_o),
    .ad_o      (bus_ad_o),
    .ad_oe_o   (bus_ad_oe_o),
    .addr_o    (bus_addr_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_done_o  = (state_q == ST_DONE);
  assign rsp_rdata_o = rdata_q;
  assign bus_cs_no   = !((state_q == ST_ADDR) || (state_q == ST_QUAL) ||
                         (state_q == ST_DATA) || open_q);
  assign bus_rd_no   = !(((state_q == ST_DATA) && !wr_q) || open_q);
  assign bus_wr_no   = !((state_q == ST_DATA) && wr_q);

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no));
  p_cs_cover_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_no || !bus_rd_no || bus_ale_o) |-> !bus_cs_no);
  p_strobe_timer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_no) |-> tmr_active);
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  p_ale_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> (!bus_ale_o && !bus_cs_no));
  p_fifo_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL && wr_q && fifo_full_i) |=> bus_wr_no);
  p_fifo_no_ale_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL) |-> !bus_ale_o);
endmodule

// File: tb/test_hb8_ctrl.sv
module test_hb8_ctrl;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = '0, cfg_rd_ws = '0, cfg_wr_ws = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0, bus_ad_in = '0;
  logic          fifo_full = 1'b0, fifo_empty = 1'b0;
  logic          req_ready, rsp_done, cs_n, rd_n, wr_n, ale, ad_oe;
  logic [7:0]    rsp_rdata, ad_out;
  logic [AW-1:0] addr_out;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit model_open = 1'b0;

  always #10 clk = ~clk;

  hb8_ctrl #(.AW(AW), .WSW(2)) i_hb8_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(cfg_mode), .cfg_rd_ws_i(cfg_rd_ws), .cfg_wr_ws_i(cfg_wr_ws),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .bus_cs_no(cs_n), .bus_rd_no(rd_n), .bus_wr_no(wr_n), .bus_ale_o(ale),
    .bus_addr_o(addr_out), .bus_ad_o(ad_out), .bus_ad_oe_o(ad_oe),
    .bus_ad_i(bus_ad_in), .fifo_full_i(fifo_full), .fifo_empty_i(fifo_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input int mode, input int rws, input int wws, input bit wr,
                         input logic [AW-1:0] addr, input logic [7:0] wdata,
                         input int stall);
    int n, pre, kdone, strobe_lo, other_lo, cs_lo, ale_hi, dmis, mis;
    bit cont, open_now, rd_at_done;
    logic [7:0] rd_byte;
    @(negedge clk);
    cfg_mode  = mode[1:0];
    cfg_rd_ws = rws[1:0];
    cfg_wr_ws = wws[1:0];
    bus_ad_in = addr[7:0] ^ 8'hA5;
    if (mode == 3) begin
      fifo_full  = wr && (stall > 0);
      fifo_empty = !wr && (stall > 0);
    end else begin
      fifo_full  = 1'b1;  // R6: ignored outside FIFO mode
      fifo_empty = 1'b1;
    end
    @(negedge clk);
    open_now = model_open && (mode == 2);
    chk(rd_n == !open_now && cs_n == !open_now, "R7 open/release before request",
        int'(rd_n), int'(!open_now));
    cont = open_now && !wr;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata;
    n   = 2 * ((wr ? wws : rws) + 1);
    pre = cont ? 0 : ((mode == 3) ? ((stall > 1) ? stall : 1) : 1);
    kdone = 0; strobe_lo = 0; other_lo = 0; cs_lo = 0; ale_hi = 0; dmis = 0;
    rd_at_done = 1'b1; rd_byte = '0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        chk(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
      end
      if (rsp_done) begin
        kdone = k; rd_at_done = rd_n; rd_byte = rsp_rdata;
        if (!(wr ? wr_n : rd_n) && !(mode == 2 && !wr)) strobe_lo++;
        if (!(wr ? rd_n : wr_n)) other_lo++;
        break;
      end
      if (!(wr ? wr_n : rd_n)) strobe_lo++;
      if (!(wr ? rd_n : wr_n)) other_lo++;
      if (!cs_n) cs_lo++;
      if (ale) ale_hi++;
      if (k == 1 && !cont && mode == 0)
        if (ad_out != addr[7:0] || !ad_oe) dmis++;
      if (k > pre && k <= pre + n) begin
        mis = 0;
        if (wr && (ad_out != wdata || !ad_oe)) mis = 1;
        if (!wr && mode == 0 && ad_oe) mis = 1;
        if ((mode == 1 || mode == 2) && addr_out != addr) mis = 1;
        if ((mode == 0 || mode == 3) && addr_out != '0) mis = 1;
        dmis += mis;
      end
      if (mode == 3 && stall > 0 && k == stall) begin
        fifo_full = 1'b0; fifo_empty = 1'b0;
      end
    end
    chk(kdone == pre + n + 1, mode == 3 ? "R8 done latency" :
        (cont ? "R7 done latency" : "R4 done latency"), kdone, pre + n + 1);
    chk(strobe_lo == n, wr ? "R2 write strobe width" : "R3 read strobe width",
        strobe_lo, n);
    chk(other_lo == 0, "R10 opposite strobe idle", other_lo, 0);
    chk(cs_lo == kdone - 1, "R10 chip select span", cs_lo, kdone - 1);
    chk(ale_hi == ((mode == 0) ? 1 : 0), mode == 0 ? "R5 latch enable" : "R6 latch enable",
        ale_hi, (mode == 0) ? 1 : 0);
    chk(dmis == 0, mode == 0 ? "R5 pad contents" : "R6 pad contents", dmis, 0);
    if (!wr)
      chk(rd_byte == (addr[7:0] ^ 8'hA5), "R9 read data", int'(rd_byte),
          int'(addr[7:0] ^ 8'hA5));
    chk(rd_at_done == !(mode == 2 && !wr), "R7 strobe at done", int'(rd_at_done),
        int'(!(mode == 2 && !wr)));
    @(negedge clk);
    chk(!rsp_done && req_ready, "R9 done one cycle", int'(rsp_done), 0);
    model_open = (mode == 2) && !wr;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    chk(cs_n && rd_n && wr_n && !ale && req_ready && !rsp_done, "R1 reset idle",
        {cs_n, rd_n, wr_n, ale, req_ready, rsp_done}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int w = 1; w >= 0; w--)
        for (int ws = 0; ws < 4; ws++) begin
          a = AW'(16'h1000 * m + 16'h0111 * ws + 16'h0808 * w + 16'h0024);
          run_txn(m, ws, 3 - ws, w[0], a, a[15:8] ^ a[7:0] ^ 8'h3C, 0);
        end
    // R8: FIFO stalls on full and empty
    run_txn(3, 1, 2, 1'b1, 16'h0000, 8'hC3, 3);
    run_txn(3, 2, 0, 1'b0, 16'h0000, 8'h00, 4);
    // R7: open read released by write, then reopened and continued
    run_txn(2, 0, 0, 1'b0, 16'h4A11, 8'h00, 0);
    run_txn(2, 0, 1, 1'b1, 16'h4A12, 8'h77, 0);
    run_txn(2, 1, 0, 1'b0, 16'h4A13, 8'h00, 0);
    run_txn(2, 3, 0, 1'b0, 16'h4A14, 8'h00, 0);
    run_txn(1, 0, 0, 1'b0, 16'h0B0B, 8'h00, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule